// File: doc/BRIEF.md
# Six-Function 32-bit ALU

This block is the arithmetic-logic unit of a small load/store processor datapath. It is purely combinational: two 32-bit operands and a 4-bit operation code go in, and a 32-bit result plus a zero indication come out in the same cycle. The main control path picks the operation code from the instruction type and function field.

Six operations are implemented: three bitwise ones (AND, OR, NOR), wrapping addition and subtraction, and a signed set-on-less-than. The zero output lets a branch-on-equal instruction compare two registers by subtracting them. Any code outside the six defined ones produces a result of zero. Carry-out and overflow are not reported.

Top module: `alu6_core`

## Requirements
- R1: With op = 4'b0000 the result is the bitwise AND of A and B.
- R2: With op = 4'b0001 the result is the bitwise OR of A and B.
- R3: With op = 4'b0010 the result is A + B modulo 2^32, and the carry-out is discarded.
- R4: With op = 4'b0110 the result is A - B modulo 2^32, and the borrow is discarded.
- R5: With op = 4'b0111 the result is 1 when A is less than B as signed two's-complement numbers and 0 otherwise; bits 31 down to 1 are always zero.
- R6: With op = 4'b1100 the result is the bitwise NOR of A and B.
- R7: The zero output is 1 exactly when all 32 result bits are 0, for every op code.
- R8: Every op code other than the six above gives a result of 0 (and so zero = 1), whatever A and B are.
- R9: The block holds no state: result and zero depend only on the present A, B and op, and settle in the same cycle the inputs change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a_i | input | 32 | First operand (minuend for subtraction) |
| opnd_b_i | input | 32 | Second operand (subtrahend for subtraction) |
| op_i | input | 4 | Operation code |
| result_o | output | 32 | Operation result |
| zero_o | output | 1 | High when result_o is all zeros |

## Verification
Every output of this block is due zero cycles after its stimulus, since no register lies between the inputs and result or zero. The bench changes the inputs one time unit after a rising clock edge and compares result and zero at the following falling edge, half a period later, so each queued expectation is checked against exactly the inputs it was computed from. Expectations come from a reference model written in the bench, covering random operands, signed and unsigned extremes, and all sixteen op codes.

// File: rtl/alu6_pkg.sv
// Package: shared widths and operation codes of the six-function ALU.
// Assumes a 4-bit operation code; code values are fixed by the datapath control.
package alu6_pkg;

    localparam int unsigned ALU_W = 32;
    localparam int unsigned OP_W  = 4;

    typedef enum logic [OP_W-1:0] {
        OP_AND = 4'b0000,
        OP_OR  = 4'b0001,
        OP_ADD = 4'b0010,
        OP_SUB = 4'b0110,
        OP_SLT = 4'b0111,
        OP_NOR = 4'b1100
    } alu_op_e;

    // Classify an operation code as one of the six defined ones.
    function automatic logic op_is_defined(input logic [OP_W-1:0] code);
        case (code)
            OP_AND, OP_OR, OP_ADD, OP_SUB, OP_SLT, OP_NOR: return 1'b1;
            default:                                     return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/alu6_bitwise.sv
// Module: alu6_bitwise
// Computes the three bitwise functions of the ALU in parallel, one slice per bit.
// Assumes nothing about the operands; all outputs are purely combinational.
module alu6_bitwise #(
    parameter int unsigned WIDTH = alu6_pkg::ALU_W
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] and_o,
    output logic [WIDTH-1:0] or_o,
    output logic [WIDTH-1:0] nor_o
);

    // One independent logic slice per bit position.
    for (genvar g = 0; g < WIDTH; g++) begin : g_slice
        logic s_and;
        logic s_or;

        // Per-bit gate evaluation.
        always_comb begin
            s_and = a_i[g] & b_i[g];
            s_or  = a_i[g] | b_i[g];
        end

        assign and_o[g] = s_and;
        assign or_o[g]  = s_or;
        assign nor_o[g] = ~s_or;
    end

endmodule

// File: rtl/alu6_addsub.sv
// Module: alu6_addsub
// Shared adder that produces A+B or A-B (two's complement, carry dropped), and the
// signed less-than flag of A against B.
// Assumes sub_i selects subtraction; the less flag is only meaningful then,
// but is computed from the sign bits so it never depends on overflow.
module alu6_addsub #(
    parameter int unsigned WIDTH = alu6_pkg::ALU_W
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             less_o
);

    localparam int unsigned MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH-1:0] cin_vec;

    // Invert B and inject a carry of one when subtracting.
    always_comb begin
        b_eff   = sub_i ? ~b_i : b_i;
        cin_vec = '0;
        cin_vec[0] = sub_i;
    end

    // Single wrapping adder; the carry-out is not kept.
    always_comb begin
        sum_o = a_i + b_eff + cin_vec;
    end

    // Signed compare: differing signs decide directly, equal signs use the difference sign.
    always_comb begin
        if (a_i[MSB] != b_i[MSB]) begin
            less_o = a_i[MSB];
        end else begin
            less_o = sum_o[MSB];
        end
    end

endmodule

// File: rtl/alu6_select.sv
// Module: alu6_select
// Chooses the ALU result by operation code and derives the zero indication.
// Assumes all candidate results are already settled; undefined codes give zero.
module alu6_select
    import alu6_pkg::*;
#(
    parameter int unsigned WIDTH = ALU_W
) (
    input  logic [OP_W-1:0]  op_i,
    input  logic [WIDTH-1:0] and_i,
    input  logic [WIDTH-1:0] or_i,
    input  logic [WIDTH-1:0] nor_i,
    input  logic [WIDTH-1:0] arith_i,
    input  logic             less_i,
    output logic [WIDTH-1:0] result_o,
    output logic             zero_o
);

    logic [WIDTH-1:0] slt_word;

    // Place the less-than flag in bit 0 with all upper bits cleared.
    always_comb begin
        slt_word    = '0;
        slt_word[0] = less_i;
    end

    // Result multiplexer keyed on the operation code.
    always_comb begin
        case (op_i)
            OP_AND:          result_o = and_i;
            OP_OR:           result_o = or_i;
            OP_NOR:          result_o = nor_i;
            OP_ADD, OP_SUB:  result_o = arith_i;
            OP_SLT:          result_o = slt_word;
            default:         result_o = '0;
        endcase
    end

    // Zero detection over the whole result word.
    always_comb begin
        zero_o = ~|result_o;
    end

endmodule

// File: rtl/alu6_core.sv
// Module: alu6_core (top)
// Six-function combinational ALU: AND, OR, NOR, add, subtract, signed set-on-less-than.
// Assumes the caller holds inputs steady for the settling time of one cycle; no state.
module alu6_core
    import alu6_pkg::*;
(
    input  logic [ALU_W-1:0] opnd_a_i,
    input  logic [ALU_W-1:0] opnd_b_i,
    input  logic [OP_W-1:0]  op_i,
    output logic [ALU_W-1:0] result_o,
    output logic             zero_o
);

    logic [ALU_W-1:0] and_w;
    logic [ALU_W-1:0] or_w;
    logic [ALU_W-1:0] nor_w;
    logic [ALU_W-1:0] arith_w;
    logic             less_w;
    logic             sub_w;

    // The adder subtracts for both subtraction and set-on-less-than.
    always_comb begin
        sub_w = (op_i == OP_SUB) || (op_i == OP_SLT);
    end

    alu6_bitwise #(.WIDTH(ALU_W)) u_bitwise (
        .a_i   (opnd_a_i),
        .b_i   (opnd_b_i),
        .and_o (and_w),
        .or_o  (or_w),
        .nor_o (nor_w)
    );

    alu6_addsub #(.WIDTH(ALU_W)) u_addsub (
        .a_i    (opnd_a_i),
        .b_i    (opnd_b_i),
        .sub_i  (sub_w),
        .sum_o  (arith_w),
        .less_o (less_w)
    );

    alu6_select #(.WIDTH(ALU_W)) u_select (
        .op_i     (op_i),
        .and_i    (and_w),
        .or_i     (or_w),
        .nor_i    (nor_w),
        .arith_i  (arith_w),
        .less_i   (less_w),
        .result_o (result_o),
        .zero_o   (zero_o)
    );

endmodule

// File: rtl/alu6_core_chk.sv
// Module: alu6_core_chk
// Property checker for alu6_core, attached by bind. The block has no clock, so the
// checks are immediate assertions evaluated whenever the ports settle.
module alu6_core_chk
    import alu6_pkg::*;
(
    input logic [ALU_W-1:0] opnd_a_i,
    input logic [ALU_W-1:0] opnd_b_i,
    input logic [OP_W-1:0]  op_i,
    input logic [ALU_W-1:0] result_o,
    input logic             zero_o
);

    // Port-level relations checked on every settled input change.
    always_comb begin
        if (!$isunknown({opnd_a_i, opnd_b_i, op_i})) begin
            // R1: an AND result has no bit set that is clear in either operand
            if (op_i == OP_AND) begin
                p_and_subset_r1: assert ((result_o & ~opnd_a_i) == '0 && (result_o & ~opnd_b_i) == '0);
            end
            // R2: an OR result covers both operands
            if (op_i == OP_OR) begin
                p_or_cover_r2: assert ((opnd_a_i & ~result_o) == '0 && (opnd_b_i & ~result_o) == '0);
            end
            // R3: the sum minus B gives back A
            if (op_i == OP_ADD) begin
                p_add_inverse_r3: assert (result_o - opnd_b_i == opnd_a_i);
            end
            // R4: the difference plus B gives back A
            if (op_i == OP_SUB) begin
                p_sub_inverse_r4: assert (result_o + opnd_b_i == opnd_a_i);
            end
            // R5: set-on-less-than only ever sets bit 0
            if (op_i == OP_SLT) begin
                p_slt_upper_r5: assert (result_o[ALU_W-1:1] == '0);
            end
            // R6: a NOR result shares no bit with either operand
            if (op_i == OP_NOR) begin
                p_nor_disjoint_r6: assert ((result_o & (opnd_a_i | opnd_b_i)) == '0);
            end
            // R7: zero flag agrees with the result word
            p_zero_flag_r7: assert (zero_o == (result_o == '0));
            // R8: undefined codes give zero
            if (!op_is_defined(op_i)) begin
                p_undef_zero_r8: assert (result_o == '0 && zero_o);
            end
        end
    end

endmodule

bind alu6_core alu6_core_chk u_chk (
    .opnd_a_i (opnd_a_i),
    .opnd_b_i (opnd_b_i),
    .op_i     (op_i),
    .result_o (result_o),
    .zero_o   (zero_o)
);

// File: tb/alu6_core_test.sv
// Scoreboard bench for alu6_core: a driver task applies stimulus just after a rising
// edge and queues the expected outcome; a monitor compares at the falling edge.
module alu6_core_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 100000;

    typedef struct {
        logic [3:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] res;
        logic        zero;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] a = '0;
    logic [31:0] b = '0;
    logic [3:0]  op = '0;
    logic [31:0] result;
    logic        zero;

    int   total = 0;
    int   bad   = 0;
    bit   done  = 0;
    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    alu6_core uut (
        .opnd_a_i (a),
        .opnd_b_i (b),
        .op_i     (op),
        .result_o (result),
        .zero_o   (zero)
    );

    // Reference model built from the requirements.
    function automatic logic [31:0] ref_res(input logic [3:0] c, input logic [31:0] x, input logic [31:0] y);
        case (c)
            4'b0000: return x & y;                                   // R1
            4'b0001: return x | y;                                   // R2
            4'b0010: return x + y;                                   // R3
            4'b0110: return x - y;                                   // R4
            4'b0111: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0; // R5
            4'b1100: return ~(x | y);                                // R6
            default: return 32'd0;                                   // R8
        endcase
    endfunction

    function automatic string ref_tag(input logic [3:0] c);
        case (c)
            4'b0000: return "R1";
            4'b0001: return "R2";
            4'b0010: return "R3";
            4'b0110: return "R4";
            4'b0111: return "R5";
            4'b1100: return "R6";
            default: return "R8";
        endcase
    endfunction

    // Driver: apply one operation and queue its expected outcome.
    task automatic drive(input logic [3:0] c, input logic [31:0] x, input logic [31:0] y);
        exp_t e;
        @(posedge clk);
        #1;
        op = c; a = x; b = y;
        e.op = c; e.a = x; e.b = y;
        e.res  = ref_res(c, x, y);
        e.zero = (e.res == 32'd0);
        e.tag  = ref_tag(c);
        sb_q.push_back(e);
    endtask

    // Monitor: compare settled outputs half a period after the stimulus (R9: same cycle).
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            total++;
            if (result !== e.res) begin
                bad++;
                $display("FAIL %s (R9 same-cycle): op=%b a=%h b=%h result=%h expected=%h",
                         e.tag, e.op, e.a, e.b, result, e.res);
            end
            total++;
            if (zero !== e.zero) begin
                bad++;
                $display("FAIL R7: op=%b a=%h b=%h zero=%b expected=%b",
                         e.op, e.a, e.b, zero, e.zero);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Watchdog: an expired run counts as one failed check.
    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: cycles=%0d expected=<%0d", WATCHDOG_CYCLES, WATCHDOG_CYCLES);
        finish_run();
    end

    logic [31:0] corners [6] = '{32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF,
                                 32'h8000_0000, 32'h7FFF_FFFF, 32'hA5A5_5A5A};
    logic [3:0]  defined_ops [6] = '{4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1100};

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Reset state: all-zero inputs give AND result 0, zero flag 1 (R1, R7).
        #1;
        total++;
        if (result !== 32'd0 || zero !== 1'b1) begin
            bad++;
            $display("FAIL R7 reset: result=%h zero=%b expected=00000000 1", result, zero);
        end
        // Corner operands across every defined code.
        foreach (defined_ops[k]) begin
            foreach (corners[i]) begin
                foreach (corners[j]) begin
                    drive(defined_ops[k], corners[i], corners[j]);
                end
            end
        end
        // R3 wrap: carry-out discarded.
        drive(4'b0010, 32'hFFFF_FFFF, 32'h0000_0001);
        // R4 wrap: borrow discarded, equal operands give zero for branch-on-equal.
        drive(4'b0110, 32'h0000_0000, 32'h0000_0001);
        drive(4'b0110, 32'h1234_5678, 32'h1234_5678);
        // R5 signed: negative below positive, unsigned order would say the opposite.
        drive(4'b0111, 32'h8000_0000, 32'h7FFF_FFFF);
        drive(4'b0111, 32'h7FFF_FFFF, 32'h8000_0000);
        drive(4'b0111, 32'hFFFF_FFFF, 32'h0000_0000);
        // R8: every code, including the undefined ones, with busy operands.
        for (int c = 0; c < 16; c++) begin
            drive(4'(c), 32'hDEAD_BEEF, 32'h0F0F_F0F0);
            drive(4'(c), 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        end
        // Random operands on every code.
        for (int n = 0; n < 2000; n++) begin
            drive(4'($urandom_range(0, 15)), $urandom, $urandom);
        end
        // Random operands close together to stress R5 and R7.
        for (int n = 0; n < 500; n++) begin
            logic [31:0] x;
            x = $urandom;
            drive(4'b0111, x, x + 32'($urandom_range(0, 2)) - 32'd1);
            drive(4'b0110, x, x ^ 32'($urandom_range(0, 1)));
        end
        // Back-to-back changes: each cycle's output reflects only that cycle (R9).
        drive(4'b0010, 32'd5, 32'd7);
        drive(4'b0000, 32'd5, 32'd7);
        drive(4'b1100, 32'd5, 32'd7);
        @(posedge clk);
        @(negedge clk);
        #1;
        finish_run();
    end

endmodule